// File: doc/BRIEF.md
# Streaming Banked Matrix-Vector MAC Engine

This engine multiplies a small batch of signed 16-bit input vectors by a large signed 16-bit weight matrix. The vectors are written once into a local buffer while the engine is idle. The weights then arrive as several parallel bank streams. Each bank feeds its own group of multiply lanes, and every beat carries one slice of a weight row. Each lane group multiplies its slice against the matching slice of one buffered vector, adds the lane products, and keeps one running partial sum per vector.

A beat is held at the inputs for M consecutive cycles, one cycle per buffered vector. The vectors therefore stay resident and are reused, and each weight is fetched only once. After the last beat of a row, a final stage adds the partial sums of all banks. It then applies a rounding arithmetic right shift and saturates the value to signed 32 bits. One result per output element leaves through a valid/ready output.

The controller has four states. In IDLE, vector writes are accepted and a start pulse latches M, K, N and the shift amount; this is the transition `launch` to RUN. In RUN, one (beat, vector) step is taken per cycle while the inputs allow it. Taking the final step of the final row is the transition `last_step` to DRAIN. In DRAIN, the engine waits until the final result is accepted; that handshake is the transition `last_accept` to FINISH. FINISH lasts one cycle, raises `done` and returns to IDLE through the transition `retire`.

Top module: `mvm_engine`

## Requirements
- R1: After reset, and whenever the engine is idle, `busy`, `done`, `o_valid` and all `w_ready` bits are low.
- R2: A write with `vld_we` high in IDLE stores `vld_data` as element `vld_idx` of vector `vld_vec`; later operations use that value.
- R3: While `busy` is high, `start` pulses and vector-buffer writes are ignored: the running operation keeps its M, K and N, and the buffer contents are unchanged.
- R4: All bank streams advance in lockstep. A beat is consumed only on a cycle where every `w_valid` bit and `w_ready` are high. All `w_ready` bits always carry the same value.
- R5: Lane l of bank b in beat j of a row carries weight index k = j*BANKS*LANES + b*LANES + l, with lane 0 in the least significant 16 bits of each bank's field. Lanes with k >= K are ignored. Each row takes ceil(K/(BANKS*LANES)) beats.
- R6: Before scaling, the result for vector m and row n is the exact signed sum over k < K of vector[m][k] * weight[n][k].
- R7: Scaling is an arithmetic right shift by `cfg_shift` with round-half-up: floor((x + 2^(s-1)) / 2^s) for s > 0, and x unchanged for s = 0.
- R8: A scaled value above 2^31-1 is output as 0x7FFFFFFF, and one below -2^31 is output as 0x80000000.
- R9: Results leave in row-major order: for row 0 vectors 0..M-1, then row 1, and so on. `o_last` is high only on the M*N-th result, and no further result follows.
- R10: While `o_valid` is high and `o_ready` is low, `o_data` and `o_last` stay stable and every `w_ready` bit is low.
- R11: `done` is high for exactly the one cycle after the final result is accepted, and `busy` is low in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted in IDLE only) |
| cfg_m | input | clog2(MAX_M+1) | Number of vectors M, 1..MAX_M |
| cfg_k | input | clog2(MAX_K+1) | Reduction length K, 1..MAX_K |
| cfg_n | input | clog2(MAX_N+1) | Number of weight rows N, 1..MAX_N |
| cfg_shift | input | SH_W | Right-shift amount for scaling |
| busy | output | 1 | High from launch through FINISH |
| done | output | 1 | One-cycle pulse after the last result |
| vld_we | input | 1 | Vector buffer write enable |
| vld_vec | input | idx(MAX_M) | Vector index of the write |
| vld_idx | input | idx(MAX_K) | Element index of the write |
| vld_data | input | DW | Signed element value |
| w_valid | input | BANKS | Per-bank weight beat valid |
| w_ready | output | BANKS | Per-bank weight beat ready (all equal) |
| w_data | input | BANKS*LANES*DW | Weight beats, bank b in field b |
| o_valid | output | 1 | Result valid |
| o_ready | input | 1 | Result accepted by the sink |
| o_data | output | OW | Signed scaled, saturated result |
| o_last | output | 1 | Marks the final result of the operation |

## Verification
The bench builds the engine with BANKS=2, LANES=2, MAX_M=4, MAX_K=10 and MAX_N=6. Each beat is then four weights wide, so a ten-element reduction ends in a part-filled beat whose padding lanes carry garbage. Ten products of extreme 16-bit values exceed the 32-bit range, which brings both saturation limits within reach. The largest batch and the largest row count each take only a few dozen cycles, so random bank gaps and output backpressure can be applied across many complete operations.

// File: rtl/mvm_pkg.sv
package mvm_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RUN,
        S_DRAIN,
        S_FINISH
    } mvm_state_e;

    // index width of a range of n entries, never below one bit
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mvm_vec_buf.sv
module mvm_vec_buf
    import mvm_pkg::*;
#(
    parameter int DW    = 16,
    parameter int MAX_M = 14,
    parameter int MAX_K = 256,
    parameter int W     = 128,
    parameter int KW    = 9
) (
    input  logic                                   clk,
    input  logic                                   we,
    input  logic [idx_w(MAX_M)-1:0]                wr_vec,
    input  logic [idx_w(MAX_K)-1:0]                wr_idx,
    input  logic [DW-1:0]                          wr_data,
    input  logic [idx_w(MAX_M)-1:0]                rd_vec,
    input  logic [idx_w((MAX_K+W-1)/W)-1:0]        rd_beat,
    input  logic [KW-1:0]                          k_len,
    output logic [W*DW-1:0]                        rd_slice
);

    localparam int DEPTH = MAX_M * MAX_K;
    localparam int AW    = idx_w(DEPTH);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (int'(wr_vec) < MAX_M) && (int'(wr_idx) < MAX_K)) begin
            mem[AW'(int'(wr_vec) * MAX_K + int'(wr_idx))] <= wr_data;
        end
    end

    // one beat-wide slice; positions past K read as zero so padded lanes drop out
    always_comb begin
        for (int j = 0; j < W; j++) begin
            int kk;
            kk = int'(rd_beat) * W + j;
            if ((kk < int'(k_len)) && (kk < MAX_K)) begin
                rd_slice[j*DW +: DW] = mem[AW'(int'(rd_vec) * MAX_K + kk)];
            end else begin
                rd_slice[j*DW +: DW] = '0;
            end
        end
    end

endmodule

// File: rtl/mvm_lane_group.sv
module mvm_lane_group
    import mvm_pkg::*;
#(
    parameter int DW    = 16,
    parameter int LANES = 16,
    parameter int MAX_M = 14,
    parameter int ACC_W = 42
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        step,
    input  logic                        first,
    input  logic [idx_w(MAX_M)-1:0]     m_sel,
    input  logic [LANES*DW-1:0]         w_slice,
    input  logic [LANES*DW-1:0]         v_slice,
    output logic signed [ACC_W-1:0]     partial
);

    logic signed [ACC_W-1:0] prod [LANES];
    logic signed [ACC_W-1:0] beat_sum;
    logic signed [ACC_W-1:0] acc  [MAX_M];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic signed [2*DW-1:0] p;
        assign p       = $signed(w_slice[l*DW +: DW]) * $signed(v_slice[l*DW +: DW]);
        assign prod[l] = {{(ACC_W-2*DW){p[2*DW-1]}}, p};
    end

    // lane products of one beat reduced to a single term
    always_comb begin
        beat_sum = '0;
        for (int l = 0; l < LANES; l++) begin
            beat_sum = beat_sum + prod[l];
        end
    end

    assign partial = (first ? '0 : acc[m_sel]) + beat_sum;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_M; i++) begin
                acc[i] <= '0;
            end
        end else if (step) begin
            acc[m_sel] <= partial;
        end
    end

endmodule

// File: rtl/mvm_reduce_scale.sv
module mvm_reduce_scale #(
    parameter int BANKS = 8,
    parameter int ACC_W = 42,
    parameter int OW    = 32,
    parameter int SH_W  = 5
) (
    input  logic [BANKS*ACC_W-1:0] parts,
    input  logic [SH_W-1:0]        shift,
    output logic [OW-1:0]          result
);

    localparam int SUM_W = ACC_W + $clog2(BANKS + 1) + 1;

    logic signed [SUM_W-1:0] total;
    logic signed [SUM_W-1:0] half;
    logic signed [SUM_W-1:0] shifted;
    logic signed [SUM_W-1:0] sat_hi;
    logic signed [SUM_W-1:0] sat_lo;

    assign sat_hi = $signed({{(SUM_W-OW+1){1'b0}}, {(OW-1){1'b1}}});
    assign sat_lo = $signed({{(SUM_W-OW+1){1'b1}}, {(OW-1){1'b0}}});

    always_comb begin
        total = '0;
        for (int b = 0; b < BANKS; b++) begin
            total = total + $signed({{(SUM_W-ACC_W){parts[b*ACC_W+ACC_W-1]}},
                                     parts[b*ACC_W +: ACC_W]});
        end
    end

    assign half    = (shift == '0) ? '0 : $signed(SUM_W'(1) << (shift - 1'b1));
    assign shifted = (total + half) >>> shift;

    always_comb begin
        if (shifted > sat_hi) begin
            result = sat_hi[OW-1:0];
        end else if (shifted < sat_lo) begin
            result = sat_lo[OW-1:0];
        end else begin
            result = shifted[OW-1:0];
        end
    end

endmodule

// File: rtl/mvm_engine.sv
module mvm_engine
    import mvm_pkg::*;
#(
    parameter int DW    = 16,
    parameter int OW    = 32,
    parameter int BANKS = 8,
    parameter int LANES = 16,
    parameter int MAX_M = 14,
    parameter int MAX_K = 256,
    parameter int MAX_N = 1024,
    parameter int SH_W  = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [$clog2(MAX_M+1)-1:0]    cfg_m,
    input  logic [$clog2(MAX_K+1)-1:0]    cfg_k,
    input  logic [$clog2(MAX_N+1)-1:0]    cfg_n,
    input  logic [SH_W-1:0]               cfg_shift,
    output logic                          busy,
    output logic                          done,
    input  logic                          vld_we,
    input  logic [idx_w(MAX_M)-1:0]       vld_vec,
    input  logic [idx_w(MAX_K)-1:0]       vld_idx,
    input  logic [DW-1:0]                 vld_data,
    input  logic [BANKS-1:0]              w_valid,
    output logic [BANKS-1:0]              w_ready,
    input  logic [BANKS*LANES*DW-1:0]     w_data,
    output logic                          o_valid,
    input  logic                          o_ready,
    output logic [OW-1:0]                 o_data,
    output logic                          o_last
);

    localparam int W        = BANKS * LANES;
    localparam int GW       = LANES * DW;
    localparam int MW       = $clog2(MAX_M + 1);
    localparam int KW       = $clog2(MAX_K + 1);
    localparam int NW       = $clog2(MAX_N + 1);
    localparam int MIDX_W   = idx_w(MAX_M);
    localparam int NIDX_W   = idx_w(MAX_N);
    localparam int BEAT_MAX = (MAX_K + W - 1) / W;
    localparam int BEAT_W   = idx_w(BEAT_MAX);
    localparam int BCNT_W   = $clog2(BEAT_MAX + 1);
    localparam int ACC_W    = 2 * DW + $clog2(MAX_K + 1) + 1;

    mvm_state_e state_q, state_d;

    logic [MW-1:0]     m_q;
    logic [KW-1:0]     k_q;
    logic [NW-1:0]     n_q;
    logic [SH_W-1:0]   sh_q;
    logic [BCNT_W-1:0] beats_q;

    logic [MIDX_W-1:0] m_idx;
    logic [BEAT_W-1:0] beat_idx;
    logic [NIDX_W-1:0] n_idx;

    logic          o_valid_q;
    logic [OW-1:0] o_data_q;
    logic          o_last_q;

    logic launch, stall, all_valid, step;
    logic last_m, last_beat, last_n;

    logic [W*DW-1:0]        v_slice;
    logic [BANKS*ACC_W-1:0] part_flat;
    logic [OW-1:0]          scaled;

    // ---------------------------------------------------------------- control terms
    assign launch    = (state_q == S_IDLE) && start;
    assign stall     = o_valid_q && !o_ready;
    assign all_valid = &w_valid;
    assign step      = (state_q == S_RUN) && all_valid && !stall;
    assign last_m    = (m_idx == MIDX_W'(m_q - 1'b1));
    assign last_beat = (beat_idx == BEAT_W'(beats_q - 1'b1));
    assign last_n    = (n_idx == NIDX_W'(n_q - 1'b1));

    // ---------------------------------------------------------------- state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------------------------------------------------------- transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) state_d = S_RUN;                       // launch
            end
            S_RUN: begin
                if (step && last_m && last_beat && last_n) begin
                    state_d = S_DRAIN;                            // last_step
                end
            end
            S_DRAIN: begin
                if (o_valid_q && o_ready) state_d = S_FINISH;     // last_accept
            end
            S_FINISH: begin
                state_d = S_IDLE;                                 // retire
            end
            default: state_d = S_IDLE;
        endcase
    end

    // ---------------------------------------------------------------- state outputs
    always_comb begin
        busy    = 1'b1;
        done    = 1'b0;
        w_ready = '0;
        unique case (state_q)
            S_IDLE:   busy = 1'b0;
            S_RUN:    w_ready = {BANKS{!stall && last_m}};
            S_DRAIN:  ;
            S_FINISH: done = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    // ---------------------------------------------------------------- operation registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q      <= '0;
            k_q      <= '0;
            n_q      <= '0;
            sh_q     <= '0;
            beats_q  <= '0;
            m_idx    <= '0;
            beat_idx <= '0;
            n_idx    <= '0;
        end else if (launch) begin
            m_q      <= cfg_m;
            k_q      <= cfg_k;
            n_q      <= cfg_n;
            sh_q     <= cfg_shift;
            beats_q  <= BCNT_W'((int'(cfg_k) + W - 1) / W);
            m_idx    <= '0;
            beat_idx <= '0;
            n_idx    <= '0;
        end else if (step) begin
            if (!last_m) begin
                m_idx <= m_idx + 1'b1;
            end else begin
                m_idx <= '0;
                if (!last_beat) begin
                    beat_idx <= beat_idx + 1'b1;
                end else begin
                    beat_idx <= '0;
                    n_idx    <= last_n ? '0 : n_idx + 1'b1;
                end
            end
        end
    end

    // ---------------------------------------------------------------- result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid_q <= 1'b0;
            o_data_q  <= '0;
            o_last_q  <= 1'b0;
        end else if (step && last_beat) begin
            o_valid_q <= 1'b1;
            o_data_q  <= scaled;
            o_last_q  <= last_m && last_n;
        end else if (o_ready) begin
            o_valid_q <= 1'b0;
        end
    end

    assign o_valid = o_valid_q;
    assign o_data  = o_data_q;
    assign o_last  = o_last_q;

    // ---------------------------------------------------------------- datapath
    mvm_vec_buf #(
        .DW    (DW),
        .MAX_M (MAX_M),
        .MAX_K (MAX_K),
        .W     (W),
        .KW    (KW)
    ) u_vbuf (
        .clk      (clk),
        .we       (vld_we && (state_q == S_IDLE)),
        .wr_vec   (vld_vec),
        .wr_idx   (vld_idx),
        .wr_data  (vld_data),
        .rd_vec   (m_idx),
        .rd_beat  (beat_idx),
        .k_len    (k_q),
        .rd_slice (v_slice)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic signed [ACC_W-1:0] part;

        mvm_lane_group #(
            .DW    (DW),
            .LANES (LANES),
            .MAX_M (MAX_M),
            .ACC_W (ACC_W)
        ) u_group (
            .clk     (clk),
            .rst_n   (rst_n),
            .step    (step),
            .first   (beat_idx == '0),
            .m_sel   (m_idx),
            .w_slice (w_data[b*GW +: GW]),
            .v_slice (v_slice[b*GW +: GW]),
            .partial (part)
        );

        assign part_flat[b*ACC_W +: ACC_W] = part;
    end

    mvm_reduce_scale #(
        .BANKS (BANKS),
        .ACC_W (ACC_W),
        .OW    (OW),
        .SH_W  (SH_W)
    ) u_final (
        .parts  (part_flat),
        .shift  (sh_q),
        .result (scaled)
    );

endmodule

// File: rtl/mvm_engine_chk.sv
module mvm_engine_chk #(
    parameter int BANKS = 8,
    parameter int OW    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic [BANKS-1:0] w_ready,
    input logic             o_valid,
    input logic             o_ready,
    input logic [OW-1:0]    o_data,
    input logic             o_last
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!o_valid && !done && (w_ready == '0)));

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_ready) |=> (o_valid && $stable(o_data) && $stable(o_last)));

    // R10
    stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_ready) |-> (w_ready == '0));

    // R11
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(o_valid && o_ready && o_last));

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

endmodule

bind mvm_engine mvm_engine_chk #(
    .BANKS (BANKS),
    .OW    (OW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .w_ready (w_ready),
    .o_valid (o_valid),
    .o_ready (o_ready),
    .o_data  (o_data),
    .o_last  (o_last)
);

// File: tb/mvm_engine_tb.sv
module mvm_engine_tb;

    localparam int DW     = 16;
    localparam int OW     = 32;
    localparam int BANKS  = 2;
    localparam int LANES  = 2;
    localparam int MAX_M  = 4;
    localparam int MAX_K  = 10;
    localparam int MAX_N  = 6;
    localparam int SH_W   = 5;
    localparam int W      = BANKS * LANES;
    localparam int MW     = $clog2(MAX_M + 1);
    localparam int KW     = $clog2(MAX_K + 1);
    localparam int NW     = $clog2(MAX_N + 1);
    localparam int MIDX_W = mvm_pkg::idx_w(MAX_M);
    localparam int KIDX_W = mvm_pkg::idx_w(MAX_K);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic                      start = 1'b0;
    logic [MW-1:0]             cfg_m = '0;
    logic [KW-1:0]             cfg_k = '0;
    logic [NW-1:0]             cfg_n = '0;
    logic [SH_W-1:0]           cfg_shift = '0;
    logic                      busy, done;
    logic                      vld_we = 1'b0;
    logic [MIDX_W-1:0]         vld_vec = '0;
    logic [KIDX_W-1:0]         vld_idx = '0;
    logic [DW-1:0]             vld_data = '0;
    logic [BANKS-1:0]          w_valid = '0;
    logic [BANKS-1:0]          w_ready;
    logic [BANKS*LANES*DW-1:0] w_data = '0;
    logic                      o_valid;
    logic                      o_ready = 1'b0;
    logic [OW-1:0]             o_data;
    logic                      o_last;

    mvm_engine #(
        .DW(DW), .OW(OW), .BANKS(BANKS), .LANES(LANES),
        .MAX_M(MAX_M), .MAX_K(MAX_K), .MAX_N(MAX_N), .SH_W(SH_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_m(cfg_m), .cfg_k(cfg_k), .cfg_n(cfg_n), .cfg_shift(cfg_shift),
        .busy(busy), .done(done),
        .vld_we(vld_we), .vld_vec(vld_vec), .vld_idx(vld_idx), .vld_data(vld_data),
        .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data),
        .o_valid(o_valid), .o_ready(o_ready), .o_data(o_data), .o_last(o_last)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic signed [DW-1:0] vb [MAX_M][MAX_K];
    logic signed [DW-1:0] wt [MAX_N][MAX_K];
    logic [OW-1:0] expq [$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic longint ref_out(input int m, input int n, input int k_len, input int sh);
        longint acc = 0;
        for (int k = 0; k < k_len; k++) acc += longint'(vb[m][k]) * longint'(wt[n][k]);
        if (sh > 0) acc = (acc + (64'sd1 <<< (sh - 1))) >>> sh;
        if (acc > 64'sd2147483647)  acc = 64'sd2147483647;
        if (acc < -64'sd2147483648) acc = -64'sd2147483648;
        return acc;
    endfunction

    task automatic load_vectors(input int m_cnt, input int k_len);
        for (int m = 0; m < m_cnt; m++) begin
            for (int k = 0; k < k_len; k++) begin
                @(negedge clk);
                vld_we   = 1'b1;
                vld_vec  = MIDX_W'(m);
                vld_idx  = KIDX_W'(k);
                vld_data = vb[m][k];
            end
        end
        @(negedge clk);
        vld_we = 1'b0;
    endtask

    // R4 R5: banks raise valid independently; a bank's field holds garbage until its valid rises
    task automatic drive_weights(input int m_cnt, input int k_len, input int n_cnt);
        int beats = (k_len + W - 1) / W;
        for (int n = 0; n < n_cnt; n++) begin
            for (int j = 0; j < beats; j++) begin
                bit hs = 1'b0;
                bit first = 1'b1;
                while (!hs) begin
                    @(negedge clk);
                    if (first) begin
                        w_valid = '0;
                        for (int i = 0; i < W; i++) w_data[i*DW +: DW] = DW'($urandom);
                        first = 1'b0;
                    end
                    for (int b = 0; b < BANKS; b++) begin
                        if (!w_valid[b] && ($urandom % 3 != 0)) begin
                            w_valid[b] = 1'b1;
                            for (int l = 0; l < LANES; l++) begin
                                int k = j * W + b * LANES + l;
                                w_data[(b*LANES+l)*DW +: DW] = (k < k_len) ? wt[n][k] : DW'($urandom);
                            end
                        end
                    end
                    #8;
                    if (!(w_ready == '0 || w_ready == '1))
                        chk(1'b0, "R4", "w_ready bits differ", longint'(w_ready), 0);
                    hs = (&w_valid) && w_ready[0];
                end
                @(posedge clk);
            end
        end
        @(negedge clk);
        w_valid = '0;
    endtask

    task automatic collect(input int total, input int bp, input string tag);
        int got = 0;
        bit held = 1'b0;
        logic [OW-1:0] hd = '0;
        logic hl = 1'b0;
        while (got < total) begin
            @(negedge clk);
            o_ready = (($urandom % 4) >= bp);
            #8;
            if (held && o_valid) begin
                chk(o_data == hd && o_last == hl, "R10", "output changed while stalled",
                    longint'(o_data), longint'(hd));
            end
            if (o_valid && !o_ready) begin
                chk(w_ready == '0, "R10", "w_ready high during stall", longint'(w_ready), 0);
                held = 1'b1; hd = o_data; hl = o_last;
            end else if (o_valid && o_ready) begin
                held = 1'b0;
                chk(o_data == expq[got], tag, $sformatf("result %0d", got),
                    longint'($signed(o_data)), longint'($signed(expq[got])));
                chk(o_last == (got == total - 1), "R9", $sformatf("last flag at %0d", got),
                    longint'(o_last), longint'(got == total - 1));
                got++;
                @(posedge clk);
            end
        end
        @(negedge clk);
        o_ready = 1'b0;
        chk(done == 1'b1, "R11", "done after last accept", longint'(done), 1);
        chk(o_valid == 1'b0, "R9", "no result after last", longint'(o_valid), 0);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R11", "done one cycle then idle",
            longint'({done, busy}), 0);
    endtask

    task automatic run_op(input int m_cnt, input int k_len, input int n_cnt, input int sh,
                          input int bp, input bit interfere, input string tag);
        load_vectors(m_cnt, k_len);
        expq.delete();
        for (int n = 0; n < n_cnt; n++)
            for (int m = 0; m < m_cnt; m++)
                expq.push_back(OW'(ref_out(m, n, k_len, sh)));
        @(negedge clk);
        cfg_m = MW'(m_cnt); cfg_k = KW'(k_len); cfg_n = NW'(n_cnt); cfg_shift = SH_W'(sh);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        fork
            drive_weights(m_cnt, k_len, n_cnt);
            collect(m_cnt * n_cnt, bp, tag);
            if (interfere) begin
                repeat (3) @(negedge clk);
                chk(busy == 1'b1, "R3", "busy while interfering", longint'(busy), 1);
                start = 1'b1; cfg_m = 1; cfg_k = 1; cfg_n = 1;
                vld_we = 1'b1; vld_vec = '0; vld_idx = '0; vld_data = ~vb[0][0];
                @(negedge clk);
                start = 1'b0; vld_we = 1'b0;
            end
        join
    endtask

    task automatic fill_random(input int m_cnt, input int k_len, input int n_cnt, input int mag);
        for (int m = 0; m < m_cnt; m++)
            for (int k = 0; k < k_len; k++)
                vb[m][k] = DW'(int'($urandom % (2 * mag + 1)) - mag);
        for (int n = 0; n < n_cnt; n++)
            for (int k = 0; k < k_len; k++)
                wt[n][k] = DW'(int'($urandom % (2 * mag + 1)) - mag);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!busy && !done && !o_valid && w_ready == '0, "R1", "reset state",
            longint'({busy, done, o_valid, w_ready}), 0);

        // R2 R5 R6: padded final beat, moderate values, no shift
        fill_random(3, 10, 4, 3000);
        run_op(3, 10, 4, 0, 0, 1'b0, "R2/R5/R6");

        // R6: single full beat, single element
        fill_random(1, 4, 1, 30000);
        run_op(1, 4, 1, 0, 1, 1'b0, "R6");

        // R7: round half up on odd values of both signs
        vb[0][0] = 16'sd3;  vb[1][0] = -16'sd3;
        wt[0][0] = 16'sd1;  wt[1][0] = 16'sd5;
        run_op(2, 1, 2, 1, 0, 1'b0, "R7");

        // R8: extremes drive both saturation limits
        for (int k = 0; k < 10; k++) begin
            vb[0][k] = -16'sd32768; vb[1][k] = 16'sd32767;
            wt[0][k] = -16'sd32768; wt[1][k] = 16'sd32767;
            wt[2][k] = DW'($urandom);
        end
        run_op(2, 10, 3, 0, 1, 1'b0, "R8");

        // R3 R10: start and vector writes while busy, heavy backpressure
        fill_random(3, 10, 5, 20000);
        run_op(3, 10, 5, 6, 3, 1'b1, "R3/R10");

        // R9: largest batch and row count
        fill_random(4, 10, 6, 32767);
        run_op(4, 10, 6, 9, 2, 1'b0, "R9/R6");

        // R6 R7 R8: random shapes and shifts
        for (int t = 0; t < 6; t++) begin
            int mm = 1 + $urandom % MAX_M;
            int kk = 1 + $urandom % MAX_K;
            int nn = 1 + $urandom % MAX_N;
            fill_random(mm, kk, nn, 32767);
            run_op(mm, kk, nn, $urandom % 12, $urandom % 3, t[0], "R6/R7/R8");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule